// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Band Decoder

This block produces the switching decision for one phase leg of an odd-level multilevel inverter. It takes a signed fixed-point reference sample every clock. It compares that sample against a stack of in-phase triangular carriers. Each carrier fills one band of unit height, so a build with N levels has N-1 carriers and bands. The comparisons give two things per band: a flag that says whether the reference sits in or above that band, and a pulse that says whether the reference is above that band's carrier right now.

Adjacent flags are combined with XOR to give a band-select vector that is strictly one-hot. The bottom band uses its own threshold test so that an over-driven negative reference still selects it. This vector tells the downstream switch-mapping logic which band is in use, so topologies where a device drops out of conduction at higher levels can be driven correctly. The block also gives a signed level code: the upper edge of the active band when its pulse is high, and the lower edge when its pulse is low.

All carriers share one up/down counter. The height of a band, in reference units, is a parameter. All outputs are registered.

Top module: `lspwm_band_decoder`

## Requirements
- R1: While `rst` is high, the carrier count is cleared to 0 with direction up. On the clock edge after any edge sampled in reset, `band_sel`, `band_pulse` and `level` all read 0.
- R2: The shared count steps by exactly one per clock. It rises 0,1,…,BAND_H and then falls back to 0, for a period of 2·BAND_H clocks. Band k (k = 1 at the top) has floor F(k) = (HALF−k)·BAND_H, where HALF = (LEVELS−1)/2. Its carrier value is F(k) plus the count.
- R3: For bands k = 1 … N−2, the band flag is 1 exactly when the reference is strictly greater than F(k). The bottom band's flag is 1 exactly when the reference is less than or equal to the bottom band's ceiling, F(N−1)+BAND_H.
- R4: `band_sel` bit k−1 stands for band k, so bit 0 is the top band. The top bit is the top flag and the bottom bit is the bottom flag. Every other bit is the XOR of its own flag and the flag of the band above. Outside reset the vector is always one-hot.
- R5: `band_pulse` bit k−1 is 1 exactly when the reference is strictly greater than the carrier value of band k. This holds for every band, active or not.
- R6: `level` is a two's-complement code. For active band k it equals HALF−k+1 when that band's pulse is 1, and HALF−k when the pulse is 0.
- R7: A reference above +HALF·BAND_H gives level +HALF. A reference below −HALF·BAND_H gives level −HALF, at any carrier phase.
- R8: A reference exactly equal to an inner band boundary belongs to the band below that boundary.
- R9: Every output reflects the reference and count sampled at a clock edge, and appears right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | REF_W | Signed reference sample |
| band_sel | output | LEVELS-1 | One-hot active band, bit 0 = top band |
| band_pulse | output | LEVELS-1 | Per-band comparison against its carrier |
| level | output | LVL_W | Signed instantaneous level code |

## Verification
The bench drives references onto every band boundary and one unit to either side. A design that used the wrong strictness in a comparison would place the boundary sample in the band above, or light two bands at once. It also drives deep positive and negative overmodulation. A bottom band that reused the generic floor test would drop to an all-zero selection and a wrong level there. A fixed reference held inside one band across more than a full carrier period checks the counter turnarounds. An off-by-one in the turnaround shows up as a pulse edge in the wrong cycle. A reset in mid-run checks that the carrier phase restarts from zero.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;
  typedef enum logic {CNT_UP = 1'b0, CNT_DN = 1'b1} cnt_dir_e;

  // Lower edge of band k (k = 1 is the top band), in reference units.
  function automatic int band_floor(input int k, input int half, input int band_h);
    return (half - k) * band_h;
  endfunction
endpackage

// File: rtl/lspwm_tri_counter.sv
module lspwm_tri_counter #(
  parameter int BAND_H = 64,
  parameter int CNT_W  = $clog2(BAND_H + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);
  import lspwm_pkg::*;

  localparam logic [CNT_W-1:0] TOP_M1 = CNT_W'(BAND_H - 1);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  cnt_dir_e         dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= CNT_UP;
    end else if (dir_q == CNT_UP) begin
      cnt_q <= cnt_q + ONE;
      if (cnt_q == TOP_M1) dir_q <= CNT_DN;
    end else begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) dir_q <= CNT_UP;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lspwm_band_cmp.sv
module lspwm_band_cmp #(
  parameter int LEVELS = 13,
  parameter int BAND_H = 64,
  parameter int REF_W  = 12,
  parameter int CNT_W  = $clog2(BAND_H + 1),
  localparam int NCAR  = LEVELS - 1,
  localparam int HALF  = (LEVELS - 1) / 2
) (
  input  logic signed [REF_W-1:0] ref_i,
  input  logic        [CNT_W-1:0] cnt_i,
  output logic        [NCAR-1:0]  flag_o,
  output logic        [NCAR-1:0]  pulse_o
);
  import lspwm_pkg::*;

  logic signed [REF_W:0] ref_x;
  logic signed [REF_W:0] cnt_x;
  assign ref_x = {ref_i[REF_W-1], ref_i};
  assign cnt_x = $signed({{(REF_W + 1 - CNT_W){1'b0}}, cnt_i});

  for (genvar g = 0; g < NCAR; g++) begin : g_band
    localparam int FLOOR = band_floor(g + 1, HALF, BAND_H);
    localparam logic signed [REF_W:0] FLOOR_X = (REF_W + 1)'(FLOOR);
    localparam logic signed [REF_W:0] CEIL_X  = (REF_W + 1)'(FLOOR + BAND_H);

    logic signed [REF_W:0] carrier;
    assign carrier    = FLOOR_X + cnt_x;
    assign pulse_o[g] = ref_x > carrier;

    if (g < NCAR - 1) begin : g_mid
      assign flag_o[g] = ref_x > FLOOR_X;
    end else begin : g_bottom
      assign flag_o[g] = ref_x <= CEIL_X;
    end
  end
endmodule

// File: rtl/lspwm_band_select.sv
module lspwm_band_select #(
  parameter int NCAR = 12
) (
  input  logic [NCAR-1:0] flag_i,
  output logic [NCAR-1:0] sel_o
);
  for (genvar g = 0; g < NCAR; g++) begin : g_sel
    if (g == 0 || g == NCAR - 1) begin : g_edge
      assign sel_o[g] = flag_i[g];
    end else begin : g_inner
      assign sel_o[g] = flag_i[g] ^ flag_i[g-1];
    end
  end
endmodule

// File: rtl/lspwm_level_enc.sv
module lspwm_level_enc #(
  parameter int LEVELS = 13,
  localparam int NCAR  = LEVELS - 1,
  localparam int HALF  = (LEVELS - 1) / 2,
  localparam int LVL_W = $clog2(HALF + 1) + 1
) (
  input  logic [NCAR-1:0]         sel_i,
  input  logic [NCAR-1:0]         pulse_i,
  output logic signed [LVL_W-1:0] level_o
);
  always_comb begin
    level_o = '0;
    for (int g = 0; g < NCAR; g++) begin
      if (sel_i[g]) begin
        level_o = pulse_i[g] ? LVL_W'(HALF - g) : LVL_W'(HALF - g - 1);
      end
    end
  end
endmodule

// File: rtl/lspwm_band_decoder.sv
module lspwm_band_decoder #(
  parameter int LEVELS = 13,
  parameter int BAND_H = 64,
  parameter int REF_W  = 12,
  localparam int NCAR  = LEVELS - 1,
  localparam int HALF  = (LEVELS - 1) / 2,
  localparam int LVL_W = $clog2(HALF + 1) + 1,
  localparam int CNT_W = $clog2(BAND_H + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_i,
  output logic [NCAR-1:0]         band_sel,
  output logic [NCAR-1:0]         band_pulse,
  output logic signed [LVL_W-1:0] level
);
  logic [CNT_W-1:0]         cnt_w;
  logic [NCAR-1:0]          flag_w;
  logic [NCAR-1:0]          pulse_w;
  logic [NCAR-1:0]          sel_w;
  logic signed [LVL_W-1:0]  level_w;

  lspwm_tri_counter #(.BAND_H(BAND_H), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (cnt_w)
  );

  lspwm_band_cmp #(.LEVELS(LEVELS), .BAND_H(BAND_H), .REF_W(REF_W), .CNT_W(CNT_W)) u_cmp (
    .ref_i   (ref_i),
    .cnt_i   (cnt_w),
    .flag_o  (flag_w),
    .pulse_o (pulse_w)
  );

  lspwm_band_select #(.NCAR(NCAR)) u_sel (
    .flag_i (flag_w),
    .sel_o  (sel_w)
  );

  lspwm_level_enc #(.LEVELS(LEVELS)) u_enc (
    .sel_i   (sel_w),
    .pulse_i (pulse_w),
    .level_o (level_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      band_sel   <= '0;
      band_pulse <= '0;
      level      <= '0;
    end else begin
      band_sel   <= sel_w;
      band_pulse <= pulse_w;
      level      <= level_w;
    end
  end
endmodule

// File: rtl/lspwm_band_decoder_chk.sv
module lspwm_band_decoder_chk #(
  parameter int LEVELS = 13,
  parameter int BAND_H = 64,
  parameter int REF_W  = 12,
  localparam int NCAR  = LEVELS - 1,
  localparam int HALF  = (LEVELS - 1) / 2,
  localparam int LVL_W = $clog2(HALF + 1) + 1,
  localparam int CNT_W = $clog2(BAND_H + 1)
) (
  input logic                    clk,
  input logic                    rst,
  input logic signed [REF_W-1:0] ref_i,
  input logic [NCAR-1:0]         band_sel,
  input logic [NCAR-1:0]         band_pulse,
  input logic signed [LVL_W-1:0] level,
  input logic [CNT_W-1:0]        cnt
);
  localparam logic signed [REF_W:0] SAT_HI = (REF_W + 1)'(HALF * BAND_H);
  localparam logic signed [REF_W:0] SAT_LO = -(REF_W + 1)'(HALF * BAND_H);

  logic run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  logic [CNT_W:0] cnt_x;
  assign cnt_x = {1'b0, cnt};
  logic signed [REF_W:0] ref_x;
  assign ref_x = {ref_i[REF_W-1], ref_i};

  // R4
  band_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> $countones(band_sel) == 1);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_x <= (CNT_W + 1)'(BAND_H));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_x == $past(cnt_x) + 1'b1) || (cnt_x + 1'b1 == $past(cnt_x)));

  // R7
  sat_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && ref_x > SAT_HI) |=> level == LVL_W'(HALF));

  // R7
  sat_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && ref_x < SAT_LO) |=> level == -LVL_W'(HALF));

  for (genvar g = 0; g < NCAR; g++) begin : g_lvl
    // R6
    level_band_chk: assert property (@(posedge clk) disable iff (rst)
      (run_q && band_sel[g]) |->
        level == (band_pulse[g] ? LVL_W'(HALF - g) : LVL_W'(HALF - g - 1)));
  end
endmodule

bind lspwm_band_decoder lspwm_band_decoder_chk #(
  .LEVELS(LEVELS), .BAND_H(BAND_H), .REF_W(REF_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ref_i      (ref_i),
  .band_sel   (band_sel),
  .band_pulse (band_pulse),
  .level      (level),
  .cnt        (cnt_w)
);

// File: tb/lspwm_band_decoder_tb.sv
`timescale 1ns/1ps
module lspwm_band_decoder_tb;
  localparam int LEVELS = 13;
  localparam int BAND_H = 64;
  localparam int REF_W  = 12;
  localparam int NCAR   = LEVELS - 1;
  localparam int HALF   = (LEVELS - 1) / 2;
  localparam int LVL_W  = $clog2(HALF + 1) + 1;

  typedef struct {
    logic [NCAR-1:0] band;
    logic [NCAR-1:0] pulse;
    int              lvl;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [REF_W-1:0] ref_i = '0;
  logic [NCAR-1:0]         band_sel;
  logic [NCAR-1:0]         band_pulse;
  logic signed [LVL_W-1:0] level;

  int checks = 0;
  int fails  = 0;
  int m_cnt  = 0;
  bit m_dn   = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  lspwm_band_decoder #(.LEVELS(LEVELS), .BAND_H(BAND_H), .REF_W(REF_W)) u_dut (
    .clk(clk), .rst(rst), .ref_i(ref_i),
    .band_sel(band_sel), .band_pulse(band_pulse), .level(level)
  );

  // Carrier count as R2 states it.
  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_dn <= 1'b0;
    end else if (!m_dn) begin
      m_cnt <= m_cnt + 1;
      if (m_cnt + 1 == BAND_H) m_dn <= 1'b1;
    end else begin
      m_cnt <= m_cnt - 1;
      if (m_cnt - 1 == 0) m_dn <= 1'b0;
    end
  end

  function automatic exp_t predict(input int r, input int c, input string tag);
    exp_t e;
    logic [NCAR-1:0] fl;
    e.tag = tag;
    e.lvl = 0;
    for (int k = 1; k <= NCAR; k++) begin
      int fl_k = (HALF - k) * BAND_H;
      fl[k-1]      = (k < NCAR) ? (r > fl_k) : (r <= fl_k + BAND_H);
      e.pulse[k-1] = r > fl_k + c;
    end
    for (int k = 1; k <= NCAR; k++) begin
      if (k == 1 || k == NCAR) e.band[k-1] = fl[k-1];
      else                     e.band[k-1] = fl[k-1] ^ fl[k-2];
      if (e.band[k-1]) e.lvl = e.pulse[k-1] ? HALF - k + 1 : HALF - k;
    end
    return e;
  endfunction

  task automatic drive(input int r, input string tag);
    @(negedge clk);
    ref_i = REF_W'(r);
    sb.push_back(predict(r, m_cnt, tag));
  endtask

  // Monitor: pops the item pushed before the preceding edge (R9 latency).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (band_sel !== e.band) begin
          fails++;
          $display("FAIL %s/R4 band_sel act=%b exp=%b", e.tag, band_sel, e.band);
        end else if (band_pulse !== e.pulse) begin
          fails++;
          $display("FAIL %s/R5 band_pulse act=%b exp=%b", e.tag, band_pulse, e.pulse);
        end else if (int'(level) != e.lvl) begin
          fails++;
          $display("FAIL %s/R6 level act=%0d exp=%0d", e.tag, int'(level), e.lvl);
        end
      end
    end
  end

  task automatic check_reset(input string tag);
    @(posedge clk);
    #1;
    checks++;
    if (band_sel !== '0 || band_pulse !== '0 || level !== '0) begin
      fails++;
      $display("FAIL %s band=%b pulse=%b level=%0d exp=0/0/0",
               tag, band_sel, band_pulse, int'(level));
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    // R1: reset state, with a nonzero reference applied
    ref_i = REF_W'(200);
    check_reset("R1");
    check_reset("R1");
    @(negedge clk);
    rst = 1'b0;

    // R2: reference held inside band 7 over more than a carrier period
    for (int i = 0; i < 2 * BAND_H + 6; i++) drive(-BAND_H / 2, "R2");

    // R3 R5 R6: sweep across every band at shifting carrier phases
    for (int r = -HALF * BAND_H; r <= HALF * BAND_H; r += 5) drive(r, "R3");

    // R8: every boundary and one unit either side
    for (int k = 1; k <= NCAR; k++) begin
      int f = (HALF - k) * BAND_H;
      drive(f, "R8");
      drive(f + 1, "R8");
      drive(f - 1, "R8");
    end

    // R7: overmodulation both ways
    drive(HALF * BAND_H + 1, "R7");
    drive(HALF * BAND_H + 90, "R7");
    drive(2047, "R7");
    drive(-HALF * BAND_H - 1, "R7");
    drive(-HALF * BAND_H - 90, "R7");
    drive(-2048, "R7");
    for (int i = 0; i < 20; i++) drive((i % 2 == 0) ? 1500 : -1500, "R7");

    // R1: mid-run reset restarts the carrier phase
    drive(BAND_H / 3, "R1");
    @(negedge clk);
    rst = 1'b1;
    ref_i = REF_W'(-300);
    check_reset("R1");
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 12; i++) drive(BAND_H / 4 + i, "R1");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule